// File: doc/BRIEF.md
# Multiperspective Feature Generator

This block turns each cache access into a vector of feature values for a perceptron reuse predictor that sits further down the pipeline. An access arrives with its program counter, physical address, the way it touches, whether it hit and whether it is a fill. The block combines that access with what it remembers about earlier accesses and emits one packed word holding every feature. It remembers three things: the PCs of the most recent accesses, one "last access missed" bit per set, and the way each set touched last, which it treats as that set's MRU way.

The mix of features is fixed at elaboration through a configuration array. Each entry picks a feature kind and sets its bit range, its PC-history depth, a flag that XORs the result with the current access's PC, and a dead-position cutoff. The block does not use the cutoff. It passes the cutoff through so that the trainer can read it. Accesses enter on a valid/ready port and feature words leave on another. A word that is not taken stays in the single output register, and `in_ready` is low until a slot frees. When `out_ready` is high, a new access can be accepted in the same cycle that the held word leaves.

Top module: `mp_feature_gen`

## Requirements
- R1: A PC feature with depth W and range LO..HI outputs bits LO through HI of a PC, zero-extended to FEAT_W. With W=0 the PC is the current access's `in_pc`. With W=k it is the PC of the k-th earlier accepted access, or 0 if fewer than k accesses have been accepted since reset.
- R2: An address feature with range LO..HI outputs bits LO through HI of `in_addr`, zero-extended.
- R3: An offset feature outputs `in_addr[OFF_W-1:0]`. A bias feature outputs 0.
- R4: A burst feature is 1 when `in_way` equals the way of the previous accepted access to the same set. The set index is `in_addr[OFF_W +: SET_W]`. The feature is 0 if that set has not been accessed since reset.
- R5: An insert feature equals `in_fill`.
- R6: A last-miss feature is 1 when the previous accepted access to the same set had `in_hit`=0. It is 0 if there was no such access.
- R7: When a feature's XOR flag is set, its zero-extended value is XORed with `in_pc[FEAT_W-1:0]` of the same access.
- R8: `out_assoc[i*ASSOC_W +: ASSOC_W]` always equals feature i's configured cutoff. Feature i occupies `out_feat[i*FEAT_W +: FEAT_W]`.
- R9: The two ports follow these handshake rules:
  - `in_ready` = !`out_valid` || `out_ready`.
  - After an accepted access, `out_valid` is 1 in the next cycle and carries that access's features.
  - While `out_valid` is high and `out_ready` is low, `out_feat` holds its value.
  - History and per-set state change only on accepted accesses, and each change takes effect after that access's features are formed.
- R10: After reset, `out_valid` is 0, the PC history is all zero, and every set's last-miss and MRU record is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Access offered |
| in_ready | output | 1 | Access can be taken this cycle |
| in_pc | input | PC_W | PC of the access |
| in_addr | input | ADDR_W | Physical address of the access |
| in_way | input | WAY_W | Way the access touches |
| in_hit | input | 1 | Access hit (1) or missed (0) |
| in_fill | input | 1 | Access is an insertion |
| out_valid | output | 1 | Feature word available |
| out_ready | input | 1 | Consumer takes the word |
| out_feat | output | NUM_FEAT*FEAT_W | Packed feature values |
| out_assoc | output | NUM_FEAT*ASSOC_W | Per-feature dead-position cutoff |

## Verification
The feature word for an access accepted at one clock edge is due at the output one edge later. From then on it stays in place for every cycle in which it is not taken. `in_ready` is combinational and is due in the cycle it is asked for. The bench drives inputs at the falling edge and updates its reference model right then, so the state it expects is already the state after the coming rising edge. At the next falling edge it compares `out_valid`, `in_ready`, every feature and every cutoff. Feature values are compared only while `out_valid` is high.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

  typedef enum logic [2:0] {
    F_PC       = 3'd0,
    F_ADDR     = 3'd1,
    F_BURST    = 3'd2,
    F_INSERT   = 3'd3,
    F_LASTMISS = 3'd4,
    F_OFFSET   = 3'd5,
    F_BIAS     = 3'd6
  } feat_kind_e;

  typedef struct packed {
    feat_kind_e  kind;
    logic [5:0]  lo;
    logic [5:0]  hi;
    logic [1:0]  depth;
    logic        xpc;
    logic [4:0]  assoc;
  } feat_cfg_t;

  localparam int DEF_NF = 10;
  typedef feat_cfg_t [DEF_NF-1:0] cfg_vec_t;

  function automatic cfg_vec_t default_cfg();
    cfg_vec_t c;
    c[0] = '{kind: F_PC,       lo: 6'd2,  hi: 6'd9,  depth: 2'd0, xpc: 1'b0, assoc: 5'd10};
    c[1] = '{kind: F_PC,       lo: 6'd3,  hi: 6'd10, depth: 2'd1, xpc: 1'b0, assoc: 5'd11};
    c[2] = '{kind: F_PC,       lo: 6'd4,  hi: 6'd11, depth: 2'd2, xpc: 1'b1, assoc: 5'd12};
    c[3] = '{kind: F_PC,       lo: 6'd0,  hi: 6'd15, depth: 2'd3, xpc: 1'b0, assoc: 5'd13};
    c[4] = '{kind: F_ADDR,     lo: 6'd12, hi: 6'd23, depth: 2'd0, xpc: 1'b0, assoc: 5'd8};
    c[5] = '{kind: F_BURST,    lo: 6'd0,  hi: 6'd0,  depth: 2'd0, xpc: 1'b0, assoc: 5'd14};
    c[6] = '{kind: F_INSERT,   lo: 6'd0,  hi: 6'd0,  depth: 2'd0, xpc: 1'b1, assoc: 5'd5};
    c[7] = '{kind: F_LASTMISS, lo: 6'd0,  hi: 6'd0,  depth: 2'd0, xpc: 1'b0, assoc: 5'd6};
    c[8] = '{kind: F_OFFSET,   lo: 6'd0,  hi: 6'd0,  depth: 2'd0, xpc: 1'b1, assoc: 5'd9};
    c[9] = '{kind: F_BIAS,     lo: 6'd0,  hi: 6'd0,  depth: 2'd0, xpc: 1'b0, assoc: 5'd16};
    return c;
  endfunction

endpackage

// File: rtl/mpf_history.sv
module mpf_history #(
  parameter int PC_W   = 32,
  parameter int HIST_D = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift,
  input  logic [PC_W-1:0]          cur_pc,
  output logic [HIST_D*PC_W-1:0]   hist
);
  localparam int PREV = HIST_D - 1;

  logic [PC_W-1:0] prev_q [PREV];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < PREV; k++) prev_q[k] <= '0;
    end else if (shift) begin
      prev_q[0] <= cur_pc;
      for (int k = 1; k < PREV; k++) prev_q[k] <= prev_q[k-1];
    end
  end

  assign hist[PC_W-1:0] = cur_pc;
  for (genvar k = 1; k < HIST_D; k++) begin : g_tap
    assign hist[k*PC_W +: PC_W] = prev_q[k-1];
  end

  // R1: the newest history slot takes the accepted access's PC
  p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> prev_q[0] == $past(cur_pc));

endmodule

// File: rtl/mpf_set_state.sv
module mpf_set_state #(
  parameter int SET_W = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_idx,
  input  logic [WAY_W-1:0] way,
  input  logic             upd,
  input  logic             hit,
  output logic             last_miss,
  output logic             is_mru
);
  localparam int SETS = 1 << SET_W;

  logic             miss_q [SETS];
  logic             seen_q [SETS];
  logic [WAY_W-1:0] mru_q  [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        miss_q[s] <= 1'b0;
        seen_q[s] <= 1'b0;
        mru_q[s]  <= '0;
      end
    end else if (upd) begin
      miss_q[set_idx] <= !hit;
      seen_q[set_idx] <= 1'b1;
      mru_q[set_idx]  <= way;
    end
  end

  assign last_miss = miss_q[set_idx];
  assign is_mru    = seen_q[set_idx] && (mru_q[set_idx] == way);

  // R6: the set just updated records whether that access missed
  p_miss_record_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> miss_q[$past(set_idx)] == !$past(hit));

  // R4: the set just updated remembers the touched way as MRU
  p_mru_record_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (mru_q[$past(set_idx)] == $past(way)) && seen_q[$past(set_idx)]);

endmodule

// File: rtl/mpf_extract.sv
module mpf_extract
  import mpf_pkg::*;
#(
  parameter feat_cfg_t CFG    = '0,
  parameter int        PC_W   = 32,
  parameter int        ADDR_W = 32,
  parameter int        OFF_W  = 6,
  parameter int        FEAT_W = 16
) (
  input  logic [PC_W-1:0]   sel_pc,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burst,
  input  logic              fill,
  input  logic              last_miss,
  output logic [FEAT_W-1:0] feat
);
  localparam int        LO   = int'(CFG.lo);
  localparam int        WID  = int'(CFG.hi) - int'(CFG.lo) + 1;
  localparam logic [63:0] MASK = (64'd1 << WID) - 64'd1;
  localparam logic [63:0] OMASK = (64'd1 << OFF_W) - 64'd1;

  logic [FEAT_W-1:0] raw;

  always_comb begin
    case (CFG.kind)
      F_PC:       raw = FEAT_W'((64'(sel_pc) >> LO) & MASK);
      F_ADDR:     raw = FEAT_W'((64'(addr) >> LO) & MASK);
      F_BURST:    raw = FEAT_W'(burst);
      F_INSERT:   raw = FEAT_W'(fill);
      F_LASTMISS: raw = FEAT_W'(last_miss);
      F_OFFSET:   raw = FEAT_W'(64'(addr) & OMASK);
      default:    raw = '0;
    endcase
  end

  if (CFG.xpc) begin : g_xor
    assign feat = raw ^ FEAT_W'(cur_pc);
  end else begin : g_plain
    assign feat = raw;
  end

endmodule

// File: rtl/mp_feature_gen.sv
module mp_feature_gen
  import mpf_pkg::*;
#(
  parameter int        PC_W     = 32,
  parameter int        ADDR_W   = 32,
  parameter int        OFF_W    = 6,
  parameter int        SET_W    = 4,
  parameter int        WAY_W    = 2,
  parameter int        HIST_D   = 4,
  parameter int        FEAT_W   = 16,
  parameter int        ASSOC_W  = 5,
  parameter int        NUM_FEAT = DEF_NF,
  parameter feat_cfg_t [NUM_FEAT-1:0] CFG = default_cfg()
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [PC_W-1:0]             in_pc,
  input  logic [ADDR_W-1:0]           in_addr,
  input  logic [WAY_W-1:0]            in_way,
  input  logic                        in_hit,
  input  logic                        in_fill,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [NUM_FEAT*FEAT_W-1:0]  out_feat,
  output logic [NUM_FEAT*ASSOC_W-1:0] out_assoc
);
  logic                       acc;
  logic [HIST_D*PC_W-1:0]     hist;
  logic                       last_miss;
  logic                       is_mru;
  logic [NUM_FEAT*FEAT_W-1:0] feat_d;
  logic [SET_W-1:0]           set_idx;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;
  assign set_idx  = in_addr[OFF_W +: SET_W];

  mpf_history #(.PC_W(PC_W), .HIST_D(HIST_D)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift(acc), .cur_pc(in_pc), .hist(hist)
  );

  mpf_set_state #(.SET_W(SET_W), .WAY_W(WAY_W)) u_sets (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .way(in_way),
    .upd(acc), .hit(in_hit), .last_miss(last_miss), .is_mru(is_mru)
  );

  for (genvar i = 0; i < NUM_FEAT; i++) begin : g_feat
    mpf_extract #(
      .CFG(CFG[i]), .PC_W(PC_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .FEAT_W(FEAT_W)
    ) u_ext (
      .sel_pc   (hist[int'(CFG[i].depth)*PC_W +: PC_W]),
      .cur_pc   (in_pc),
      .addr     (in_addr),
      .burst    (is_mru),
      .fill     (in_fill),
      .last_miss(last_miss),
      .feat     (feat_d[i*FEAT_W +: FEAT_W])
    );
    assign out_assoc[i*ASSOC_W +: ASSOC_W] = ASSOC_W'(CFG[i].assoc);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_feat  <= '0;
    end else begin
      if (acc) begin
        out_valid <= 1'b1;
        out_feat  <= feat_d;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R9: a word not taken stays unchanged
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_feat));

  // R9: an accepted access yields a word next cycle
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

endmodule

// File: tb/mp_feature_gen_tb.sv
module mp_feature_gen_tb;
  localparam int NF = 10;
  localparam int FW = 16;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_hit = 1'b0, in_fill = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [31:0] in_pc = '0, in_addr = '0;
  logic [1:0]  in_way = '0;
  logic [NF*FW-1:0] out_feat;
  logic [NF*AW-1:0] out_assoc;

  always #2.5 clk = ~clk;

  mp_feature_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_addr(in_addr), .in_way(in_way), .in_hit(in_hit),
    .in_fill(in_fill), .out_valid(out_valid), .out_ready(out_ready),
    .out_feat(out_feat), .out_assoc(out_assoc)
  );

  // configuration as specified: kind 0 pc,1 addr,2 burst,3 insert,4 lastmiss,5 offset,6 bias
  int kind [NF] = '{0, 0, 0, 0, 1, 2, 3, 4, 5, 6};
  int lo   [NF] = '{2, 3, 4, 0, 12, 0, 0, 0, 0, 0};
  int hi   [NF] = '{9, 10, 11, 15, 23, 0, 0, 0, 0, 0};
  int dep  [NF] = '{0, 1, 2, 3, 0, 0, 0, 0, 0, 0};
  int xo   [NF] = '{0, 0, 1, 0, 0, 0, 1, 0, 1, 0};
  int asc  [NF] = '{10, 11, 12, 13, 8, 14, 5, 6, 9, 16};

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // reference state
  int unsigned prev_pc [$];
  bit          m_miss [16];
  bit          m_seen [16];
  int          m_mru  [16];
  bit          e_valid;
  int unsigned e_feat [NF];

  function automatic string tag(int i);
    if (xo[i] != 0) return "R7";
    case (kind[i])
      0: return "R1";
      1: return "R2";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R3";
    endcase
  endfunction

  function automatic int unsigned slice(longint unsigned v, int l, int h);
    return int'((v >> l) & ((64'd1 << (h - l + 1)) - 1));
  endfunction

  function automatic int unsigned model_feat(int i);
    int unsigned r;
    int s;
    s = int'(in_addr[9:6]);
    case (kind[i])
      0: begin
        if (dep[i] == 0) r = slice(in_pc, lo[i], hi[i]);
        else r = slice(prev_pc[dep[i]-1], lo[i], hi[i]);
      end
      1: r = slice(in_addr, lo[i], hi[i]);
      2: r = (m_seen[s] && m_mru[s] == int'(in_way)) ? 1 : 0;
      3: r = in_fill ? 1 : 0;
      4: r = m_miss[s] ? 1 : 0;
      5: r = in_addr[5:0];
      default: r = 0;
    endcase
    if (xo[i] != 0) r = r ^ int'(in_pc[15:0]);
    return r & 32'hFFFF;
  endfunction

  task automatic check(bit ok, string req, string what, int unsigned act, int unsigned exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check(out_valid == e_valid, "R9", "out_valid", out_valid, e_valid);
    for (int i = 0; i < NF; i++)
      check(int'(out_assoc[i*AW +: AW]) == asc[i], "R8", $sformatf("assoc[%0d]", i),
            out_assoc[i*AW +: AW], asc[i]);
    if (e_valid)
      for (int i = 0; i < NF; i++)
        check(int'(out_feat[i*FW +: FW]) == e_feat[i], tag(i),
              $sformatf("feat[%0d]", i), out_feat[i*FW +: FW], e_feat[i]);
  endtask

  task automatic step(bit v, bit rdy, bit narrow);
    bit acc;
    int s;
    compare_all();
    in_valid  = v;
    out_ready = rdy;
    in_pc     = $urandom;
    in_addr   = $urandom;
    if (narrow) in_addr[9:6] = 4'($urandom % 3);
    in_way    = 2'($urandom % 4);
    in_hit    = ($urandom % 2) != 0;
    in_fill   = ($urandom % 3) == 0;
    #1;
    check(in_ready == (!e_valid || rdy), "R9", "in_ready", in_ready, !e_valid || rdy);
    acc = v && (!e_valid || rdy);
    if (acc) begin
      for (int i = 0; i < NF; i++) e_feat[i] = model_feat(i);
      e_valid = 1;
      s = int'(in_addr[9:6]);
      prev_pc.push_front(in_pc);
      void'(prev_pc.pop_back());
      m_miss[s] = !in_hit;
      m_seen[s] = 1;
      m_mru[s]  = int'(in_way);
    end else if (rdy) begin
      e_valid = 0;
    end
  endtask

  initial begin
    #600000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) prev_pc.push_back(0);
    for (int s = 0; s < 16; s++) begin m_miss[s] = 0; m_seen[s] = 0; m_mru[s] = 0; end
    e_valid = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: first access after reset sees zero history and cleared set state
    step(1, 1, 1);
    @(negedge clk);
    check(out_feat[3*FW +: FW] == 16'h0, "R10", "history after reset", out_feat[3*FW +: FW], 0);
    check(out_feat[5*FW +: FW] == 16'h0, "R10", "burst after reset", out_feat[5*FW +: FW], 0);
    check(out_feat[7*FW +: FW] == 16'h0, "R10", "lastmiss after reset", out_feat[7*FW +: FW], 0);
    // back-to-back stream, then a stall phase, then mixed traffic
    for (int n = 0; n < 200; n++) begin step(1, 1, 1); @(negedge clk); end
    for (int n = 0; n < 40; n++)  begin step(1, 0, 0); @(negedge clk); end
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 4) != 0, ($urandom % 4) != 0, (n % 2) == 0);
      @(negedge clk);
    end
    step(0, 1, 0);
    @(negedge clk);
    compare_all();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule